// File: doc/BRIEF.md
# Decimal-capable 8-bit ALU with flag register

The block is the arithmetic and logic datapath of a small accumulator-style processor. It takes an accumulator value, a second operand, a carry input, a decimal-mode bit and a 4-bit operation code. It returns the result in the same cycle. Addition and subtraction run in plain binary or in packed BCD. The block also covers AND, OR and XOR, shifts and rotates, increment and decrement, compare and bit-test. Next to the result it gives a per-flag update mask and the new N, V, Z and C values. Those values are captured in a small flag register on the next clock edge while `valid_i` is high.

Two decimal-flag behaviours are available through `fix_i`:
- **Legacy** (`fix_i` low): with decimal mode on, N, V and Z describe the uncorrected binary sum, and only C describes the decimal result.
- **Corrected** (`fix_i` high): every flag describes the adjusted decimal result. `extra_o` is raised so that the sequencer can add the extra cycle this costs.

An operation leaves unchanged every flag it has no conceptual relation to.

Top module: `bcd_alu`

## Requirements
- R1: ADD (op 0) in binary gives A+M+C on `result_o`. C is the carry out of bit 7. V = (A7==M7) && (R7!=A7). N is R7 and Z is (R==0). The mask `upd_o` is 4'b1111, with bit order {N,V,Z,C} = bits [3:0].
- R2: SUB (op 1) in binary gives A−M−(1−C). C is 1 when no borrow occurs. V follows the R1 formula with ~M in place of M. N and Z come from the result, and the mask is 4'b1111.
- R3: ADD with `dec_i` high treats both operands as two packed BCD digits and adds them digit by digit, each digit corrected to 0–9. C is the carry out of the high digit.
- R4: SUB with `dec_i` high subtracts digit by digit, each digit corrected to 0–9. C is 1 when the high digit does not borrow.
- R5: When `fix_i` is low and decimal mode is on, N, V and Z on ADD and SUB are taken from the binary sum that the same inputs would give.
- R6: When `fix_i` is high and decimal mode is on, N, V and Z on ADD and SUB come from the decimal result. `extra_o` is high exactly when `fix_i`, `dec_i` and op ADD or SUB are all present.
- R7: AND (op 2), OR (op 3) and XOR (op 4) give the bitwise result and update only N and Z (mask 4'b1010). C and V keep their values. Decimal mode has no effect on them.
- R8: SHL (op 5) and SHR (op 6) shift in 0. ROL (op 7) and ROR (op 8) shift the carry input in. The bit shifted out goes to C, N and Z follow the result, and the mask is 4'b1011. After SHR, N is always 0.
- R9: CMP (op 9) forms A−M in binary, even when `dec_i` is high. It sets C when A ≥ M unsigned and takes N and Z from the difference. `result_o` equals A and the mask is 4'b1011.
- R10: BIT (op 10) sets Z from (A AND M)==0, N from M7 and V from M6. `result_o` equals A and the mask is 4'b1110.
- R11: INC (op 11) and DEC (op 12) give A+1 and A−1 modulo 256 and update only N and Z.
- R12: Reset clears `flags_o`. A flag is loaded at a rising clock edge only when `valid_i` is high and its mask bit is set. Op codes 13–15 return A with an empty mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Commit the selected flags at the next edge |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator or register operand |
| m_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry input |
| dec_i | input | 1 | Decimal mode for ADD and SUB |
| fix_i | input | 1 | Corrected decimal flags when high |
| result_o | output | 8 | Operation result |
| upd_o | output | 4 | Flag update mask {N,V,Z,C} |
| extra_o | output | 1 | Extra cycle request for corrected decimal |
| flags_o | output | 4 | Registered flags {N,V,Z,C} |

## Verification
The binary cases cover:
- A signed overflow into bit 7.
- A full wrap to zero with carry out.
- A subtract that borrows, a subtract that overflows, and an equal subtract with carry clear.

Together these separate the carry, overflow and zero terms. The decimal cases run the same inputs, 58+46 and 99+01, under both flag variants. Because the binary and decimal results differ in sign and zero there, this shows which result drives N, V and Z. Digit-borrow subtracts (40−13 and 00−01) exercise the per-digit correction. A logic op placed after a carry-setting op, a compare under decimal mode and a cycle with `valid_i` low show that untouched flags really hold.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_ROL = 4'd7,
    OP_ROR = 4'd8,
    OP_CMP = 4'd9,
    OP_BIT = 4'd10,
    OP_INC = 4'd11,
    OP_DEC = 4'd12
  } alu_op_e;

  localparam int NFLAG = 4;
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_V = 2;
  localparam int FLG_N = 3;

  localparam logic [NFLAG-1:0] MASK_ALL   = 4'b1111;
  localparam logic [NFLAG-1:0] MASK_NZ    = 4'b1010;
  localparam logic [NFLAG-1:0] MASK_NZC   = 4'b1011;
  localparam logic [NFLAG-1:0] MASK_NVZ   = 4'b1110;
  localparam logic [NFLAG-1:0] MASK_NONE  = 4'b0000;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] bin_res_o,
  output logic          bin_c_o,
  output logic [DW-1:0] dec_res_o,
  output logic          dec_c_o
);
  localparam int NIB = DW / 4;

  logic [DW-1:0] m_eff;
  logic [NIB:0]  cy;

  assign m_eff = sub_i ? ~m_i : m_i;
  assign {bin_c_o, bin_res_o} = {1'b0, a_i} + {1'b0, m_eff} + {{DW{1'b0}}, cin_i};

  // digit chain: carry for add, borrow for subtract
  assign cy[0] = sub_i ? ~cin_i : cin_i;

  for (genvar g = 0; g < NIB; g++) begin : g_dig
    logic [3:0] an, mn, d;
    logic [4:0] t_add;
    logic [5:0] t_sub;
    logic       co;

    assign an = a_i[4*g +: 4];
    assign mn = m_i[4*g +: 4];
    assign t_add = {1'b0, an} + {1'b0, mn} + {4'b0, cy[g]};
    assign t_sub = {2'b0, an} - {2'b0, mn} - {5'b0, cy[g]};

    always_comb begin
      if (sub_i) begin
        co = t_sub[5];
        d  = t_sub[5] ? (t_sub[3:0] + 4'd10) : t_sub[3:0];
      end else begin
        co = (t_add > 5'd9);
        d  = (t_add > 5'd9) ? (t_add[3:0] + 4'd6) : t_add[3:0];
      end
    end

    assign dec_res_o[4*g +: 4] = d;
    assign cy[g+1] = co;
  end

  assign dec_c_o = sub_i ? ~cy[NIB] : cy[NIB];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import bcd_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          c_o
);
  localparam int MSB = DW - 1;

  always_comb begin
    res_o = a_i;
    c_o   = cin_i;
    unique case (op_i)
      OP_AND: res_o = a_i & m_i;
      OP_OR:  res_o = a_i | m_i;
      OP_XOR: res_o = a_i ^ m_i;
      OP_SHL: begin res_o = {a_i[MSB-1:0], 1'b0}; c_o = a_i[MSB]; end
      OP_SHR: begin res_o = {1'b0, a_i[MSB:1]};   c_o = a_i[0];   end
      OP_ROL: begin res_o = {a_i[MSB-1:0], cin_i}; c_o = a_i[MSB]; end
      OP_ROR: begin res_o = {cin_i, a_i[MSB:1]};   c_o = a_i[0];   end
      OP_INC: res_o = a_i + {{(DW-1){1'b0}}, 1'b1};
      OP_DEC: res_o = a_i - {{(DW-1){1'b0}}, 1'b1};
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int NF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NF-1:0] ld_i,
  input  logic [NF-1:0] d_i,
  output logic [NF-1:0] q_o
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             q_o[i] <= 1'b0;
      else if (en_i && ld_i[i]) q_o[i] <= d_i[i];
    end
  end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          carry_i,
  input  logic          dec_i,
  input  logic          fix_i,
  output logic [DW-1:0] result_o,
  output logic [3:0]    upd_o,
  output logic          extra_o,
  output logic [3:0]    flags_o
);
  localparam int MSB = DW - 1;

  alu_op_e       op;
  logic          is_sub, use_bin_sub;
  logic [DW-1:0] m_eff;
  logic [DW-1:0] bin_res, dec_res, lg_res;
  logic          bin_c, dec_c, lg_c;
  logic          bin_v, dec_v;
  logic          arith_cin;
  logic [3:0]    nxt;

  assign op          = alu_op_e'(op_i);
  assign is_sub      = (op == OP_SUB);
  assign use_bin_sub = is_sub || (op == OP_CMP);
  // compare always subtracts with no incoming borrow
  assign arith_cin   = (op == OP_CMP) ? 1'b1 : carry_i;
  assign m_eff       = use_bin_sub ? ~m_i : m_i;

  alu_arith #(.DW(DW)) u_arith (
    .a_i       (a_i),
    .m_i       (m_i),
    .cin_i     (arith_cin),
    .sub_i     (use_bin_sub),
    .bin_res_o (bin_res),
    .bin_c_o   (bin_c),
    .dec_res_o (dec_res),
    .dec_c_o   (dec_c)
  );

  alu_logic #(.DW(DW)) u_logic (
    .op_i  (op),
    .a_i   (a_i),
    .m_i   (m_i),
    .cin_i (carry_i),
    .res_o (lg_res),
    .c_o   (lg_c)
  );

  assign bin_v = (a_i[MSB] == m_eff[MSB]) && (bin_res[MSB] != a_i[MSB]);
  assign dec_v = (a_i[MSB] == m_eff[MSB]) && (dec_res[MSB] != a_i[MSB]);

  always_comb begin
    result_o = a_i;
    upd_o    = MASK_NONE;
    nxt      = '0;
    extra_o  = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        upd_o = MASK_ALL;
        if (dec_i) begin
          result_o   = dec_res;
          nxt[FLG_C] = dec_c;
          if (fix_i) begin
            extra_o    = 1'b1;
            nxt[FLG_N] = dec_res[MSB];
            nxt[FLG_Z] = (dec_res == '0);
            nxt[FLG_V] = dec_v;
          end else begin
            nxt[FLG_N] = bin_res[MSB];
            nxt[FLG_Z] = (bin_res == '0);
            nxt[FLG_V] = bin_v;
          end
        end else begin
          result_o   = bin_res;
          nxt[FLG_C] = bin_c;
          nxt[FLG_N] = bin_res[MSB];
          nxt[FLG_Z] = (bin_res == '0);
          nxt[FLG_V] = bin_v;
        end
      end
      OP_CMP: begin
        upd_o      = MASK_NZC;
        nxt[FLG_N] = bin_res[MSB];
        nxt[FLG_Z] = (bin_res == '0);
        nxt[FLG_C] = bin_c;
      end
      OP_BIT: begin
        upd_o      = MASK_NVZ;
        nxt[FLG_N] = m_i[MSB];
        nxt[FLG_V] = m_i[MSB-1];
        nxt[FLG_Z] = ((a_i & m_i) == '0);
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
        upd_o      = MASK_NZ;
        result_o   = lg_res;
        nxt[FLG_N] = lg_res[MSB];
        nxt[FLG_Z] = (lg_res == '0);
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        upd_o      = MASK_NZC;
        result_o   = lg_res;
        nxt[FLG_N] = lg_res[MSB];
        nxt[FLG_Z] = (lg_res == '0);
        nxt[FLG_C] = lg_c;
      end
      default: ;
    endcase
  end

  alu_flag_reg #(.NF(NFLAG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .ld_i   (upd_o),
    .d_i    (nxt),
    .q_o    (flags_o)
  );
endmodule

// File: rtl/bcd_alu_chk.sv
module bcd_alu_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [3:0]    op_i,
  input logic [DW-1:0] a_i,
  input logic          dec_i,
  input logic          fix_i,
  input logic [DW-1:0] result_o,
  input logic [3:0]    upd_o,
  input logic          extra_o,
  input logic [3:0]    flags_o
);
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_o)); // R12

  AST_CARRY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !upd_o[0]) |=> (flags_o[0] == $past(flags_o[0]))); // R7

  AST_SHR_N_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd6) |=> !flags_o[3]); // R8

  AST_EXTRA_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    extra_o |-> (fix_i && dec_i && (op_i == 4'd0 || op_i == 4'd1))); // R6

  AST_BIT_KEEP_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd10) |-> (result_o == a_i)); // R10

  AST_LOGIC_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {4'd2, 4'd3, 4'd4}) |-> (upd_o == 4'b1010)); // R7

  AST_SPARE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'd13) |-> (upd_o == 4'b0000 && result_o == a_i)); // R12
endmodule

bind bcd_alu bcd_alu_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .a_i      (a_i),
  .dec_i    (dec_i),
  .fix_i    (fix_i),
  .result_o (result_o),
  .upd_o    (upd_o),
  .extra_o  (extra_o),
  .flags_o  (flags_o)
);

// File: tb/bcd_alu_test.sv
module bcd_alu_test;
  typedef struct packed {
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] m;
    logic       c;
    logic       d;
    logic       f;
    logic [7:0] r;
    logic [3:0] upd;
    logic [3:0] nvzc;
    logic       ex;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  8'h50, 8'h50, 1'b0, 1'b0, 1'b0, 8'hA0, 4'b1111, 4'b1100, 1'b0, 4'd1},  // R1 overflow
    '{4'd0,  8'hFF, 8'h01, 1'b0, 1'b0, 1'b0, 8'h00, 4'b1111, 4'b0011, 1'b0, 4'd1},  // R1 wrap
    '{4'd0,  8'h10, 8'h20, 1'b1, 1'b0, 1'b0, 8'h31, 4'b1111, 4'b0000, 1'b0, 4'd1},  // R1 carry in
    '{4'd1,  8'h50, 8'hF0, 1'b1, 1'b0, 1'b0, 8'h60, 4'b1111, 4'b0000, 1'b0, 4'd2},  // R2 borrow
    '{4'd1,  8'h80, 8'h01, 1'b1, 1'b0, 1'b0, 8'h7F, 4'b1111, 4'b0101, 1'b0, 4'd2},  // R2 overflow
    '{4'd1,  8'h05, 8'h05, 1'b0, 1'b0, 1'b0, 8'hFF, 4'b1111, 4'b1000, 1'b0, 4'd2},  // R2 carry clear
    '{4'd0,  8'h58, 8'h46, 1'b1, 1'b1, 1'b0, 8'h05, 4'b1111, 4'b1101, 1'b0, 4'd5},  // R3 R5 legacy
    '{4'd0,  8'h58, 8'h46, 1'b1, 1'b1, 1'b1, 8'h05, 4'b1111, 4'b0001, 1'b1, 4'd6},  // R3 R6 fixed
    '{4'd0,  8'h99, 8'h01, 1'b0, 1'b1, 1'b0, 8'h00, 4'b1111, 4'b1001, 1'b0, 4'd5},  // R5 legacy zero
    '{4'd0,  8'h99, 8'h01, 1'b0, 1'b1, 1'b1, 8'h00, 4'b1111, 4'b0011, 1'b1, 4'd6},  // R6 fixed zero
    '{4'd1,  8'h46, 8'h12, 1'b1, 1'b1, 1'b0, 8'h34, 4'b1111, 4'b0001, 1'b0, 4'd4},  // R4 simple
    '{4'd1,  8'h40, 8'h13, 1'b1, 1'b1, 1'b0, 8'h27, 4'b1111, 4'b0001, 1'b0, 4'd4},  // R4 digit borrow
    '{4'd1,  8'h00, 8'h01, 1'b1, 1'b1, 1'b1, 8'h99, 4'b1111, 4'b1000, 1'b1, 4'd4},  // R4 R6 underflow
    '{4'd1,  8'h12, 8'h12, 1'b1, 1'b1, 1'b0, 8'h00, 4'b1111, 4'b0011, 1'b0, 4'd4},  // R4 equal
    '{4'd2,  8'hF0, 8'h3C, 1'b0, 1'b0, 1'b0, 8'h30, 4'b1010, 4'b0000, 1'b0, 4'd7},  // R7 AND, C kept
    '{4'd3,  8'h80, 8'h01, 1'b0, 1'b0, 1'b0, 8'h81, 4'b1010, 4'b1000, 1'b0, 4'd7},  // R7 OR
    '{4'd4,  8'h5A, 8'h5A, 1'b0, 1'b0, 1'b0, 8'h00, 4'b1010, 4'b0010, 1'b0, 4'd7},  // R7 XOR
    '{4'd5,  8'h81, 8'h00, 1'b0, 1'b0, 1'b0, 8'h02, 4'b1011, 4'b0001, 1'b0, 4'd8},  // R8 SHL
    '{4'd6,  8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'b1011, 4'b0011, 1'b0, 4'd8},  // R8 SHR
    '{4'd7,  8'h80, 8'h00, 1'b1, 1'b0, 1'b0, 8'h01, 4'b1011, 4'b0001, 1'b0, 4'd8},  // R8 ROL
    '{4'd8,  8'h01, 8'h00, 1'b1, 1'b0, 1'b0, 8'h80, 4'b1011, 4'b1001, 1'b0, 4'd8},  // R8 ROR in
    '{4'd8,  8'h02, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 4'b1011, 4'b0000, 1'b0, 4'd8},  // R8 ROR out
    '{4'd9,  8'h40, 8'h40, 1'b0, 1'b0, 1'b0, 8'h40, 4'b1011, 4'b0011, 1'b0, 4'd9},  // R9 equal
    '{4'd9,  8'h10, 8'h20, 1'b1, 1'b0, 1'b0, 8'h10, 4'b1011, 4'b1000, 1'b0, 4'd9},  // R9 less
    '{4'd9,  8'h09, 8'h10, 1'b1, 1'b1, 1'b1, 8'h09, 4'b1011, 4'b1000, 1'b0, 4'd9},  // R9 decimal ignored
    '{4'd10, 8'h01, 8'hC0, 1'b0, 1'b0, 1'b0, 8'h01, 4'b1110, 4'b1110, 1'b0, 4'd10}, // R10 bit test
    '{4'd11, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'b1010, 4'b0010, 1'b0, 4'd11}, // R11 INC
    '{4'd12, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'hFF, 4'b1010, 4'b1000, 1'b0, 4'd11}, // R11 DEC
    '{4'd13, 8'h33, 8'hFF, 1'b1, 1'b0, 1'b0, 8'h33, 4'b0000, 4'b0000, 1'b0, 4'd12}, // R12 spare op
    '{4'd0,  8'h01, 8'h01, 1'b0, 1'b0, 1'b1, 8'h02, 4'b1111, 4'b0000, 1'b0, 4'd6},  // R6 no extra in binary
    '{4'd2,  8'hFF, 8'h81, 1'b0, 1'b1, 1'b1, 8'h81, 4'b1010, 4'b1000, 1'b0, 4'd7}   // R7 decimal no effect
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] a_i = '0;
  logic [7:0] m_i = '0;
  logic       carry_i = 1'b0;
  logic       dec_i = 1'b0;
  logic       fix_i = 1'b0;
  logic [7:0] result_o;
  logic [3:0] upd_o;
  logic       extra_o;
  logic [3:0] flags_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] shadow = '0;
  logic done = 1'b0;

  always #4 clk_i = ~clk_i;

  bcd_alu uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .a_i      (a_i),
    .m_i      (m_i),
    .carry_i  (carry_i),
    .dec_i    (dec_i),
    .fix_i    (fix_i),
    .result_o (result_o),
    .upd_o    (upd_o),
    .extra_o  (extra_o),
    .flags_o  (flags_o)
  );

  task automatic check(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    @(negedge clk_i);
    op_i = v.op; a_i = v.a; m_i = v.m; carry_i = v.c;
    dec_i = v.d; fix_i = v.f; valid_i = 1'b1;
    #1;
    check($sformatf("vec %0d result", idx), int'(v.req), result_o, v.r);
    check($sformatf("vec %0d mask", idx), int'(v.req), {4'b0, upd_o}, {4'b0, v.upd});
    check($sformatf("vec %0d extra", idx), int'(v.req), {7'b0, extra_o}, {7'b0, v.ex});
    shadow = (shadow & ~v.upd) | (v.nvzc & v.upd);
    @(posedge clk_i);
    #1;
    check($sformatf("vec %0d flags", idx), int'(v.req), {4'b0, flags_o}, {4'b0, shadow});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check("reset flags", 12, {4'b0, flags_o}, 8'h00);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R12 idle cycle: inputs that would set C and Z, but valid low
    @(negedge clk_i);
    valid_i = 1'b0; op_i = 4'd0; a_i = 8'hFF; m_i = 8'h01; carry_i = 1'b0;
    dec_i = 1'b0; fix_i = 1'b0;
    @(posedge clk_i); #1;
    check("idle hold flags", 12, {4'b0, flags_o}, {4'b0, shadow});

    // R7 carry set, then XOR must keep it
    run_vec('{4'd0, 8'hFF, 8'h02, 1'b0, 1'b0, 1'b0, 8'h01, 4'b1111, 4'b0001, 1'b0, 4'd7}, 100);
    run_vec('{4'd4, 8'h0F, 8'hF0, 1'b0, 1'b0, 1'b0, 8'hFF, 4'b1010, 4'b1000, 1'b0, 4'd7}, 101);
    check("R7 carry kept after XOR", 7, {7'b0, flags_o[0]}, 8'h01);

    // R12 reset mid-run clears flags
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("async reset", 12, {4'b0, flags_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule